// File: doc/BRIEF.md
# Fractional Clock Divider Field Encoder

This block converts a requested clock divide ratio into the counter settings a programmable clock output divider needs. The ratio has a 7-bit integer part and a 3-bit fraction counted in eighths. From these the block derives:

- the high-phase and low-phase counts
- the odd-ratio edge bit and the bypass (no-count) bit
- the fractional enable and the fraction value
- the rising and falling waveform-adjust flags
- a 3-bit fractional phase

It also packs these fields into the three 16-bit configuration words the divider takes.

Inputs are sampled on a valid strobe. Every field and packed word appears one clock later, with a one-cycle output valid pulse. Between requests the outputs hold their last result. An integer part of zero cannot be realised, so the block flags it instead.

Top module: `fdiv_encoder`

## Requirements
- R1: When `inValid` is high at a rising edge, `outValid` is high for the following cycle and all result outputs reflect that request. When `inValid` is low at a rising edge, `outValid` is low the following cycle.
- R2: An integer part of 1 sets `noCount` to 1 and every other field to 0, whatever the fraction is.
- R3: With a zero fraction and an integer part N ≥ 2, the outputs are set as follows. The low-count field is 6 bits wide, so for N = 127 the low count of 64 is encoded as 0.
  - `highCnt` is floor(N/2).
  - `edgeBit` is N mod 2.
  - `lowCnt` is N − floor(N/2), taken modulo 64.
  - `fracEn`, `fracVal`, `riseAdj`, `fallAdj` and `fracPhase` are 0.
- R4: With a non-zero fraction F and N ≥ 2, the outputs are set as follows:
  - `fracEn` is 1 and `fracVal` is F.
  - `edgeBit` is N mod 2.
  - `highCnt` is floor(N/2), less 1 when N is even.
  - `riseAdj` is 1 exactly when N is even.
- R5: With a non-zero fraction and N ≥ 2, `lowCnt` is floor(N/2), less 1 when N is even or F equals 1.
- R6: With a non-zero fraction and N ≥ 2, `fallAdj` is 1 when exactly one of (N even) and (F = 1) holds, and also when N = 2 and F = 1.
- R7: With a non-zero fraction and N ≥ 2, `fracPhase` is 4·`edgeBit` + floor(F/2).
- R8: An integer part of 0 sets `badRatio` and drives every field and packed word to 0. Any other integer clears `badRatio`.
- R9: The packed words are laid out as follows, with every other bit 0:
  - `word1`: `highCnt` in bits 11:6 and `lowCnt` in bits 5:0.
  - `word2`: `fracVal` in bits 14:12, `fracEn` in bit 11, `riseAdj` in bit 10, `edgeBit` in bit 7 and `noCount` in bit 6.
  - `word3`: `fracPhase` in bits 13:11 and `fallAdj` in bit 10.
- R10: While `inValid` stays low, every field, `badRatio` and every packed word keep their last value, whatever the data inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request strobe |
| divInt | input | 7 | Integer part of the ratio |
| divFrac | input | 3 | Fraction in eighths |
| outValid | output | 1 | Result valid pulse |
| badRatio | output | 1 | Integer part was zero |
| highCnt | output | 6 | High-phase count |
| lowCnt | output | 6 | Low-phase count |
| edgeBit | output | 1 | Odd-ratio edge bit |
| noCount | output | 1 | Divider bypass bit |
| fracEn | output | 1 | Fractional mode enable |
| fracVal | output | 3 | Fraction value |
| riseAdj | output | 1 | Rising waveform-adjust flag |
| fallAdj | output | 1 | Falling waveform-adjust flag |
| fracPhase | output | 3 | Fractional phase |
| word1 | output | 16 | Packed count word |
| word2 | output | 16 | Packed mode word |
| word3 | output | 16 | Packed phase word |

## Verification
Every result output and `outValid` comes from one register stage. A request presented at one rising edge is therefore visible from the next rising edge on. The bench drives each request on a falling edge and samples on the falling edge one clock later, which is half a cycle after the register updates. For the hold behaviour, it keeps `inValid` low while changing the data inputs, then samples one and two falling edges later to confirm that nothing moved.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;
  parameter int INT_W  = 7;
  parameter int FRAC_W = 3;
  parameter int CNT_W  = INT_W - 1;
  parameter int PH_W   = FRAC_W;
  parameter int WORD_W = 16;

  typedef struct packed {
    logic              capture;
    logic              zeroDiv;
  } ctrlStrobe_t;

  typedef struct packed {
    logic              bad;
    logic [CNT_W-1:0]  high;
    logic [CNT_W-1:0]  low;
    logic              edgeB;
    logic              noCnt;
    logic              fEn;
    logic [FRAC_W-1:0] frac;
    logic              rise;
    logic              fall;
    logic [PH_W-1:0]   phase;
  } divFields_t;
endpackage

// File: rtl/fdiv_ctrl.sv
module fdiv_ctrl
  import fdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [INT_W-1:0] divInt,
  output ctrlStrobe_t      strobe,
  output logic             validQ
);
  always_comb begin
    strobe.capture = inValid;
    strobe.zeroDiv = inValid && (divInt == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) validQ <= 1'b0;
    else       validQ <= inValid;
  end
endmodule

// File: rtl/fdiv_datapath.sv
module fdiv_datapath
  import fdiv_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [INT_W-1:0]  divInt,
  input  logic [FRAC_W-1:0] divFrac,
  output divFields_t        fieldsQ,
  output logic [WORD_W-1:0] word1,
  output logic [WORD_W-1:0] word2,
  output logic [WORD_W-1:0] word3
);
  localparam logic [CNT_W-1:0]  ONE_C = CNT_W'(1);
  localparam logic [FRAC_W-1:0] ONE_F = FRAC_W'(1);
  localparam logic [INT_W-1:0]  ONE_I = INT_W'(1);
  localparam logic [INT_W-1:0]  TWO_I = INT_W'(2);

  divFields_t       nxt;
  logic [CNT_W-1:0] halfInt;
  logic [INT_W-1:0] lowWide;
  logic             isEven;
  logic             fracOne;

  always_comb begin
    nxt     = '0;
    halfInt = divInt[INT_W-1:1];
    isEven  = ~divInt[0];
    fracOne = (divFrac == ONE_F);
    lowWide = divInt - {1'b0, halfInt};
    if (strobe.zeroDiv) begin
      nxt.bad = 1'b1;
    end else if (divInt == ONE_I) begin
      nxt.noCnt = 1'b1;
    end else if (divFrac == '0) begin
      nxt.high  = halfInt;
      nxt.edgeB = divInt[0];
      nxt.low   = lowWide[CNT_W-1:0];
    end else begin
      nxt.fEn   = 1'b1;
      nxt.frac  = divFrac;
      nxt.edgeB = divInt[0];
      nxt.high  = isEven ? halfInt - ONE_C : halfInt;
      nxt.low   = (isEven || fracOne) ? halfInt - ONE_C : halfInt;
      nxt.rise  = isEven;
      nxt.fall  = (isEven ^ fracOne) || ((divInt == TWO_I) && fracOne);
      nxt.phase = {divInt[0], divFrac[FRAC_W-1:1]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)               fieldsQ <= '0;
    else if (strobe.capture) fieldsQ <= nxt;
  end

  always_comb begin
    word1 = '0;
    word1[2*CNT_W-1:CNT_W] = fieldsQ.high;
    word1[CNT_W-1:0]       = fieldsQ.low;
    word2 = '0;
    word2[12+FRAC_W-1:12]  = fieldsQ.frac;
    word2[11]              = fieldsQ.fEn;
    word2[10]              = fieldsQ.rise;
    word2[7]               = fieldsQ.edgeB;
    word2[6]               = fieldsQ.noCnt;
    word3 = '0;
    word3[11+PH_W-1:11]    = fieldsQ.phase;
    word3[10]              = fieldsQ.fall;
  end
endmodule

// File: rtl/fdiv_encoder.sv
module fdiv_encoder
  import fdiv_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [INT_W-1:0]  divInt,
  input  logic [FRAC_W-1:0] divFrac,
  output logic              outValid,
  output logic              badRatio,
  output logic [CNT_W-1:0]  highCnt,
  output logic [CNT_W-1:0]  lowCnt,
  output logic              edgeBit,
  output logic              noCount,
  output logic              fracEn,
  output logic [FRAC_W-1:0] fracVal,
  output logic              riseAdj,
  output logic              fallAdj,
  output logic [PH_W-1:0]   fracPhase,
  output logic [WORD_W-1:0] word1,
  output logic [WORD_W-1:0] word2,
  output logic [WORD_W-1:0] word3
);
  ctrlStrobe_t strobe;
  divFields_t  fieldsQ;

  fdiv_ctrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .divInt  (divInt),
    .strobe  (strobe),
    .validQ  (outValid)
  );

  fdiv_datapath i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .divInt  (divInt),
    .divFrac (divFrac),
    .fieldsQ (fieldsQ),
    .word1   (word1),
    .word2   (word2),
    .word3   (word3)
  );

  assign badRatio  = fieldsQ.bad;
  assign highCnt   = fieldsQ.high;
  assign lowCnt    = fieldsQ.low;
  assign edgeBit   = fieldsQ.edgeB;
  assign noCount   = fieldsQ.noCnt;
  assign fracEn    = fieldsQ.fEn;
  assign fracVal   = fieldsQ.frac;
  assign riseAdj   = fieldsQ.rise;
  assign fallAdj   = fieldsQ.fall;
  assign fracPhase = fieldsQ.phase;
endmodule

// File: rtl/fdiv_encoder_chk.sv
module fdiv_encoder_chk
  import fdiv_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [INT_W-1:0]  divInt,
  input logic              outValid,
  input logic              badRatio,
  input logic [CNT_W-1:0]  highCnt,
  input logic [CNT_W-1:0]  lowCnt,
  input logic              edgeBit,
  input logic              noCount,
  input logic              fracEn,
  input logic              riseAdj,
  input logic [WORD_W-1:0] word1,
  input logic [WORD_W-1:0] word2,
  input logic [WORD_W-1:0] word3
);
  p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  p_valid_drops_r1: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  p_nocount_alone_r2: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && noCount) |-> (highCnt == '0 && lowCnt == '0 && !fracEn && !edgeBit));

  p_rise_even_r4: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && riseAdj) |-> (fracEn && !edgeBit));

  p_zero_flag_r8: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && divInt == '0) |=> (badRatio && word1 == '0 && word2 == '0 && word3 == '0));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(word1) && $stable(word2) && $stable(word3) && $stable(badRatio)));
endmodule

bind fdiv_encoder fdiv_encoder_chk i_chk (.*);

// File: tb/test_fdiv_encoder.sv
module test_fdiv_encoder;
  logic        clk = 1'b0;
  logic        rstN;
  logic        inValid;
  logic [6:0]  divInt;
  logic [2:0]  divFrac;
  logic        outValid, badRatio, edgeBit, noCount, fracEn, riseAdj, fallAdj;
  logic [5:0]  highCnt, lowCnt;
  logic [2:0]  fracVal, fracPhase;
  logic [15:0] word1, word2, word3;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fdiv_encoder i_fdiv_encoder (
    .clk(clk), .rstN(rstN), .inValid(inValid), .divInt(divInt), .divFrac(divFrac),
    .outValid(outValid), .badRatio(badRatio), .highCnt(highCnt), .lowCnt(lowCnt),
    .edgeBit(edgeBit), .noCount(noCount), .fracEn(fracEn), .fracVal(fracVal),
    .riseAdj(riseAdj), .fallAdj(fallAdj), .fracPhase(fracPhase),
    .word1(word1), .word2(word2), .word3(word3)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Expected fields computed from the requirements text
  task automatic expect_ratio(input string req, input int n, input int f);
    int eh = 0, el = 0, ee = 0, enc = 0, efe = 0, efv = 0, er = 0, efa = 0, eph = 0, eb = 0;
    logic [15:0] w1, w2, w3;
    if (n == 0) eb = 1;
    else if (n == 1) enc = 1;
    else if (f == 0) begin
      eh = n / 2; ee = n % 2; el = (n - n / 2) % 64;
    end else begin
      efe = 1; efv = f; ee = n % 2;
      eh = n / 2 - ((n % 2 == 0) ? 1 : 0);
      el = n / 2 - (((n % 2 == 0) || f == 1) ? 1 : 0);
      er = (n % 2 == 0) ? 1 : 0;
      efa = ((((n % 2 == 0) ? 1 : 0) != ((f == 1) ? 1 : 0)) || (n == 2 && f == 1)) ? 1 : 0;
      eph = ee * 4 + f / 2;
    end
    w1 = 16'(eh * 64 + el);
    w2 = 16'(efv * 4096 + efe * 2048 + er * 1024 + ee * 128 + enc * 64);
    w3 = 16'(eph * 2048 + efa * 1024);
    check(req, "outValid", 32'(outValid), 32'd1);
    check(req, "badRatio", 32'(badRatio), 32'(eb));
    check(req, "highCnt", 32'(highCnt), 32'(eh));
    check(req, "lowCnt", 32'(lowCnt), 32'(el));
    check(req, "edgeBit", 32'(edgeBit), 32'(ee));
    check(req, "noCount", 32'(noCount), 32'(enc));
    check(req, "fracEn", 32'(fracEn), 32'(efe));
    check(req, "fracVal", 32'(fracVal), 32'(efv));
    check(req, "riseAdj", 32'(riseAdj), 32'(er));
    check(req, "fallAdj", 32'(fallAdj), 32'(efa));
    check(req, "fracPhase", 32'(fracPhase), 32'(eph));
    check({req, "/R9"}, "word1", 32'(word1), 32'(w1));
    check({req, "/R9"}, "word2", 32'(word2), 32'(w2));
    check({req, "/R9"}, "word3", 32'(word3), 32'(w3));
  endtask

  // Drive on a falling edge, sample one clock later on the next falling edge
  task automatic apply(input string req, input int n, input int f);
    inValid = 1'b1; divInt = 7'(n); divFrac = 3'(f);
    @(negedge clk);
    inValid = 1'b0;
    expect_ratio(req, n, f);
  endtask

  task automatic t_reset();
    check("R1", "reset outValid", 32'(outValid), 32'd0);
    check("R1", "reset word1", 32'(word1), 32'd0);
    check("R1", "reset word2", 32'(word2), 32'd0);
    check("R1", "reset word3", 32'(word3), 32'd0);
  endtask

  task automatic t_integer_one();
    apply("R2", 1, 0);
    apply("R2", 1, 5);
  endtask

  task automatic t_plain();
    apply("R3", 2, 0);
    apply("R3", 7, 0);
    apply("R3", 40, 0);
    apply("R3", 127, 0);
  endtask

  task automatic t_fractional();
    apply("R4", 4, 3);
    apply("R4", 9, 6);
    apply("R5", 5, 1);
    apply("R5", 12, 1);
    apply("R6", 2, 1);
    apply("R6", 3, 1);
    apply("R6", 2, 2);
    apply("R7", 11, 7);
    apply("R7", 126, 5);
  endtask

  task automatic t_zero();
    apply("R4", 6, 5);
    apply("R8", 0, 3);
    apply("R8", 3, 0);
  endtask

  task automatic t_hold();
    logic [15:0] h1, h2, h3;
    apply("R10", 13, 3);
    h1 = word1; h2 = word2; h3 = word3;
    divInt = 7'd0; divFrac = 3'd6;
    @(negedge clk);
    check("R1", "outValid idle", 32'(outValid), 32'd0);
    divInt = 7'd1;
    @(negedge clk);
    check("R10", "word1 hold", 32'(word1), 32'(h1));
    check("R10", "word2 hold", 32'(word2), 32'(h2));
    check("R10", "word3 hold", 32'(word3), 32'(h3));
    check("R10", "badRatio hold", 32'(badRatio), 32'd0);
  endtask

  task automatic t_sweep();
    for (int n = 0; n < 128; n += 9)
      for (int f = 0; f < 8; f++)
        apply("R3", n, f);
  endtask

  task automatic t_back_to_back();
    inValid = 1'b1; divInt = 7'd8; divFrac = 3'd4;
    @(negedge clk);
    expect_ratio("R1", 8, 4);
    divInt = 7'd15; divFrac = 3'd2;
    @(negedge clk);
    inValid = 1'b0;
    expect_ratio("R1", 15, 2);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; inValid = 1'b0; divInt = '0; divFrac = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_integer_one();
    t_plain();
    t_fractional();
    t_zero();
    t_hold();
    t_back_to_back();
    t_sweep();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule